// File: doc/BRIEF.md
# Gated Programmable Clock Divider

This block is one channel of a clock generator. It takes several free-running source clocks, picks one, and produces a single output clock from it. The output is either the selected source passed straight through, or that source divided by an even ratio from 2 to 512. A control word written from a bus clock domain sets the source, the divide mode and the ratio, and turns the channel on and off. A sleep-mask input lets a power controller force the channel off without touching the control word.

Starting and stopping are done only at safe points, so the output never carries a runt pulse. The enable request and the sleep mask are brought into the selected source domain through a two-flop synchronizer. The gate opens and closes on a falling edge of the source. In divide mode the gate closes only while the divided clock is low. When the gate is closed, the prescaler counter and the divided output are both held at zero. The enable bit in the read-back stays at one until the gate has really closed. Software polls it before changing the source or the ratio, and writes to those fields are dropped while it reads one.

Top module: `gclk_gen`

## Requirements
- R1: After reset, `rdData` reads all zeros and `gclkOut` is low.
- R2: The control word holds the divide value DIV in bits [7:0], the divide-enable in bit 8, the source index in bits [12+SEL_W-1:12] and the enable in bit 15; other bits read as zero. A write taken while the read-back enable is zero is returned by `rdData` in the next bus cycle.
- R3: With divide-enable one, `gclkOut` has a period of 2*(DIV+1) selected source periods, and each high and low phase lasts (DIV+1) source periods.
- R4: With divide-enable zero, `gclkOut` follows the selected source: its period and its high time equal those of the source.
- R5: After the enable is written to zero, the output stops. Once the read-back enable reads zero, `gclkOut` stays low.
- R6: After a write that clears the enable while the channel is running, the read-back enable still reads one in the following bus cycle. It reads zero only after the clock has been gated off.
- R7: A write made while the read-back enable is one changes only the enable bit; the source, divide-enable and DIV fields keep their old values and the output period is unchanged.
- R8: While `sleepMask` is high, `gclkOut` is held low even though the enable bit is one. After the mask is released, the output resumes with the configured period.
- R9: After enabling, the output starts low. Its first rising edge comes no earlier than one half-period after the enabling write, and its first high pulse is a full half-period. The prescaler restarts from zero on every enable.
- R10: No high pulse of `gclkOut` is shorter than the configured half-period, across repeated enable, disable and sleep cycles.
- R11: The source index chooses which bit of `srcClk` feeds the channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| busClk | input | 1 | Clock of the control register |
| rstN | input | 1 | Asynchronous active-low reset for all flops |
| wrEn | input | 1 | Write strobe for the control word, sampled on `busClk` |
| wrData | input | 16 | Control word to write |
| rdData | output | 16 | Control word read-back, with the live enable status in bit 15 |
| srcClk | input | NUM_SRC | Free-running source clocks |
| sleepMask | input | 1 | Forces the channel off while high |
| gclkOut | output | 1 | Generated clock |

## Verification
The divider is tried with DIV at 0, 1, 2 and 255, and undivided, spread over all four sources with different periods. A wrong ratio, a wrong duty cycle or a wrong source then shows up as a measured period that does not fit. Each configuration is entered from a disabled state. Measuring the first high pulse and the delay from the enabling write to the first rising edge exposes a prescaler that was not cleared or a gate that opened mid-phase. Stops are requested both by clearing the enable and by the sleep mask, including a stop during a long high phase at DIV=255. A pulse-width monitor that runs the whole time catches any truncated pulse, and the read-back is polled to separate "stop requested" from "clock really off". A write of new fields during operation must leave both the read-back and the measured period unchanged.

// File: rtl/gclk_pkg.sv
`timescale 1ns/1ps
package gclk_pkg;
  localparam int CTRL_W    = 16;
  localparam int DIV_W     = 8;
  localparam int DIVEN_BIT = 8;
  localparam int SEL_LSB   = 12;
  localparam int EN_BIT    = 15;

  // Strobes from the register side to the clock path.
  typedef struct packed {
    logic runReq;
    logic divEn;
  } gclkStrb_t;
endpackage

// File: rtl/gclk_sync.sv
`timescale 1ns/1ps
module gclk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  generate
    if (STAGES <= 1) begin : g_single
      logic stg;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stg <= 1'b0;
        else       stg <= d;
      end
      assign q = stg;
    end else begin : g_chain
      logic [STAGES-1:0] stg;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stg <= '0;
        else       stg <= {stg[STAGES-2:0], d};
      end
      assign q = stg[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/gclk_ctrl.sv
`timescale 1ns/1ps
module gclk_ctrl
  import gclk_pkg::*;
#(
  parameter int SEL_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              busClk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [CTRL_W-1:0] wrData,
  input  logic              gateOn,
  output logic [CTRL_W-1:0] rdData,
  output gclkStrb_t         strb,
  output logic [SEL_W-1:0]  srcSel,
  output logic [DIV_W-1:0]  divVal,
  output logic              gateSeen
);
  logic enReqQ;
  logic divEnQ;
  logic [SEL_W-1:0] selQ;
  logic [DIV_W-1:0] divQ;
  logic statusOn;

  // Gate state brought back into the bus domain for the read-back.
  gclk_sync #(.STAGES(SYNC_STAGES)) u_gateSync (
    .clk (busClk),
    .rstN(rstN),
    .d   (gateOn),
    .q   (gateSeen)
  );

  assign statusOn = enReqQ | gateSeen;

  always_ff @(posedge busClk or negedge rstN) begin
    if (!rstN) begin
      enReqQ <= 1'b0;
      divEnQ <= 1'b0;
      selQ   <= '0;
      divQ   <= '0;
    end else if (wrEn) begin
      enReqQ <= wrData[EN_BIT];
      if (!statusOn) begin
        divEnQ <= wrData[DIVEN_BIT];
        selQ   <= wrData[SEL_LSB +: SEL_W];
        divQ   <= wrData[DIV_W-1:0];
      end
    end
  end

  always_comb begin
    rdData                     = '0;
    rdData[DIV_W-1:0]          = divQ;
    rdData[DIVEN_BIT]          = divEnQ;
    rdData[SEL_LSB +: SEL_W]   = selQ;
    rdData[EN_BIT]             = statusOn;
  end

  assign strb.runReq = enReqQ;
  assign strb.divEn  = divEnQ;
  assign srcSel      = selQ;
  assign divVal      = divQ;
endmodule

// File: rtl/gclk_datapath.sv
`timescale 1ns/1ps
module gclk_datapath
  import gclk_pkg::*;
#(
  parameter int NUM_SRC     = 4,
  parameter int SEL_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic [NUM_SRC-1:0] srcClk,
  input  logic               rstN,
  input  gclkStrb_t          strb,
  input  logic               sleepMask,
  input  logic [SEL_W-1:0]   srcSel,
  input  logic [DIV_W-1:0]   divVal,
  output logic               gateOn,
  output logic               gclkOut
);
  logic selClk;
  logic runRaw;
  logic runSync;
  logic [DIV_W-1:0] cntQ;
  logic divOutQ;

  // Source selection; changed only while the gate is closed.
  assign selClk = srcClk[srcSel];
  assign runRaw = strb.runReq & ~sleepMask;

  gclk_sync #(.STAGES(SYNC_STAGES)) u_runSync (
    .clk (selClk),
    .rstN(rstN),
    .d   (runRaw),
    .q   (runSync)
  );

  // Gate moves only while the source is low. In divide mode it
  // closes only while the divided clock is low as well.
  always_ff @(negedge selClk or negedge rstN) begin
    if (!rstN)                          gateOn <= 1'b0;
    else if (runSync)                   gateOn <= 1'b1;
    else if (!strb.divEn || !divOutQ)   gateOn <= 1'b0;
  end

  // Prescaler: toggle each time the count reaches the divide value.
  always_ff @(posedge selClk or negedge rstN) begin
    if (!rstN) begin
      cntQ    <= '0;
      divOutQ <= 1'b0;
    end else if (!gateOn) begin
      cntQ    <= '0;
      divOutQ <= 1'b0;
    end else if (cntQ == divVal) begin
      cntQ    <= '0;
      divOutQ <= ~divOutQ;
    end else begin
      cntQ    <= cntQ + 1'b1;
    end
  end

  assign gclkOut = gateOn & (strb.divEn ? divOutQ : selClk);
endmodule

// File: rtl/gclk_gen.sv
`timescale 1ns/1ps
module gclk_gen
  import gclk_pkg::*;
#(
  parameter int NUM_SRC     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               busClk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [CTRL_W-1:0]  wrData,
  output logic [CTRL_W-1:0]  rdData,
  input  logic [NUM_SRC-1:0] srcClk,
  input  logic               sleepMask,
  output logic               gclkOut
);
  localparam int SEL_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam logic [CTRL_W-1:0] USED_MASK =
    CTRL_W'((1 << DIV_W) - 1) | (CTRL_W'(1) << DIVEN_BIT) |
    (CTRL_W'((1 << SEL_W) - 1) << SEL_LSB) | (CTRL_W'(1) << EN_BIT);

  gclkStrb_t        strb;
  logic [SEL_W-1:0] srcSel;
  logic [DIV_W-1:0] divVal;
  logic             gateOn;
  logic             gateSeen;
  logic             unusedWr;

  assign unusedWr = ^(wrData & ~USED_MASK);

  gclk_ctrl #(.SEL_W(SEL_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .busClk  (busClk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .wrData  (wrData),
    .gateOn  (gateOn),
    .rdData  (rdData),
    .strb    (strb),
    .srcSel  (srcSel),
    .divVal  (divVal),
    .gateSeen(gateSeen)
  );

  gclk_datapath #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .srcClk   (srcClk),
    .rstN     (rstN),
    .strb     (strb),
    .sleepMask(sleepMask),
    .srcSel   (srcSel),
    .divVal   (divVal),
    .gateOn   (gateOn),
    .gclkOut  (gclkOut)
  );
endmodule

// File: rtl/gclk_gen_chk.sv
`timescale 1ns/1ps
module gclk_gen_chk
  import gclk_pkg::*;
#(
  parameter int NUM_SRC = 4
) (
  input logic              busClk,
  input logic              rstN,
  input logic              wrEn,
  input logic [CTRL_W-1:0] wrData,
  input logic [CTRL_W-1:0] rdData,
  input logic              gclkOut,
  input logic              gateSeen
);
  localparam int SEL_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam logic [CTRL_W-1:0] CFG_MASK =
    CTRL_W'((1 << DIV_W) - 1) | (CTRL_W'(1) << DIVEN_BIT) |
    (CTRL_W'((1 << SEL_W) - 1) << SEL_LSB);

  AST_WRITE_TAKES: assert property (@(posedge busClk) disable iff (!rstN)
    (wrEn && !rdData[EN_BIT]) |=> ((rdData & CFG_MASK) == ($past(wrData) & CFG_MASK))); // R2

  AST_OFF_IS_LOW: assert property (@(posedge busClk) disable iff (!rstN)
    !rdData[EN_BIT] |-> !gclkOut); // R5

  AST_STATUS_HOLDS: assert property (@(posedge busClk) disable iff (!rstN)
    (wrEn && !wrData[EN_BIT] && gateSeen) |=> rdData[EN_BIT]); // R6

  AST_CFG_LOCKED: assert property (@(posedge busClk) disable iff (!rstN)
    (wrEn && rdData[EN_BIT]) |=> ((rdData & CFG_MASK) == ($past(rdData) & CFG_MASK))); // R7
endmodule

bind gclk_gen gclk_gen_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .busClk  (busClk),
  .rstN    (rstN),
  .wrEn    (wrEn),
  .wrData  (wrData),
  .rdData  (rdData),
  .gclkOut (gclkOut),
  .gateSeen(gateSeen)
);

// File: tb/gclk_gen_bench.sv
`timescale 1ns/1ps
module gclk_gen_bench;
  localparam int CLK_PERIOD = 8;
  localparam int NUM_SRC = 4;
  localparam int SRC_PER [NUM_SRC] = '{10, 14, 6, 22};

  logic busClk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic [NUM_SRC-1:0] srcClk = '0;
  logic sleepMask = 1'b0;
  logic gclkOut;

  int nChecks = 0;
  int nFails = 0;
  bit done = 0;

  // Pulse-width reference: every high pulse at least the half-period.
  time riseT = 0;
  time runtMin = 0;
  bit runtArmed = 0;

  gclk_gen #(.NUM_SRC(NUM_SRC)) u_gclk_gen (
    .busClk(busClk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .srcClk(srcClk), .sleepMask(sleepMask), .gclkOut(gclkOut)
  );

  always #(CLK_PERIOD/2) busClk = ~busClk;
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    initial forever #(SRC_PER[g]/2) srcClk[g] = ~srcClk[g];
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge gclkOut) riseT = $time;
  always @(negedge gclkOut) begin
    if (runtArmed)
      check(($time - riseT) >= runtMin, "R10 high pulse width", $time - riseT, runtMin);
  end

  function automatic logic [15:0] word(input bit en, input int sel, input bit dEn, input int div);
    logic [15:0] w;
    w = '0;
    w[7:0] = div[7:0];
    w[8] = dEn;
    w[13:12] = sel[1:0];
    w[15] = en;
    return w;
  endfunction

  function automatic time halfOf(input int sel, input bit dEn, input int div);
    if (dEn) return time'((div + 1) * SRC_PER[sel]);
    return time'(SRC_PER[sel] / 2);
  endfunction

  task automatic busWrite(input logic [15:0] d);
    @(negedge busClk);
    wrEn = 1'b1;
    wrData = d;
    @(negedge busClk);
    wrEn = 1'b0;
  endtask

  // Steady-state period and duty measurement.
  task automatic measure(input time half, input string req);
    time t1, t2, t3;
    @(posedge gclkOut); t1 = $time;
    @(negedge gclkOut); t2 = $time;
    @(posedge gclkOut); t3 = $time;
    check((t3 - t1) == 2 * half, {req, " period"}, t3 - t1, 2 * half);
    check((t2 - t1) == half, {req, " high time"}, t2 - t1, half);
  endtask

  // Enable from a stopped state, check start-up, then the period.
  task automatic runConfig(input int sel, input bit dEn, input int div, input string req);
    time tW, tR, tF, half;
    half = halfOf(sel, dEn, div);
    runtMin = half;
    runtArmed = 1;
    @(negedge busClk);
    tW = $time;
    busWrite(word(1, sel, dEn, div));
    check(rdData == word(1, sel, dEn, div), "R2 read-back after write", rdData, word(1, sel, dEn, div));
    @(posedge gclkOut); tR = $time;
    @(negedge gclkOut); tF = $time;
    check((tR - tW) >= half, "R9 first rise delay", tR - tW, half);
    check((tF - tR) == half, "R9 first high pulse", tF - tR, half);
    measure(half, req);
  endtask

  task automatic stopAndCheck(input int sel, input bit dEn, input int div);
    int i;
    busWrite(word(0, sel, dEn, div));
    check(rdData[15] == 1'b1, "R6 enable reads one after clear", rdData[15], 1);
    i = 0;
    while (rdData[15] && i < 4000) begin
      @(negedge busClk);
      i++;
    end
    check(rdData[15] == 1'b0, "R6 enable eventually reads zero", rdData[15], 0);
    begin
      bit wentHigh;
      wentHigh = 0;
      for (int k = 0; k < 50; k++) begin
        @(negedge busClk);
        if (gclkOut) wentHigh = 1;
      end
      check(!wentHigh, "R5 output low after stop", wentHigh, 0);
    end
  endtask

  initial begin
    #(1_000_000);
    if (!done) begin
      check(0, "watchdog", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge busClk);
    rstN = 1'b1;
    @(negedge busClk);
    check(rdData == 16'h0, "R1 read-back after reset", rdData, 0);
    check(gclkOut == 1'b0, "R1 output after reset", gclkOut, 0);

    // R3 R11: source 0, DIV=1
    runConfig(0, 1, 1, "R3 div1 src0");
    // R7: new fields during run are dropped
    busWrite(word(1, 2, 0, 9));
    check(rdData == word(1, 0, 1, 1), "R7 fields kept while running", rdData, word(1, 0, 1, 1));
    measure(halfOf(0, 1, 1), "R7 period unchanged");
    stopAndCheck(0, 1, 1);

    // R3 R11: source 2, DIV=255, stop inside a long phase
    runConfig(2, 1, 255, "R3 div255 src2");
    stopAndCheck(2, 1, 255);

    // R4 R11: undivided, source 3 then source 1
    runConfig(3, 0, 0, "R4 bypass src3");
    stopAndCheck(3, 0, 0);
    runConfig(1, 0, 0, "R4 bypass src1");
    stopAndCheck(1, 0, 0);

    // R8: sleep mask on source 1, DIV=2
    runConfig(1, 1, 2, "R3 div2 src1");
    @(negedge busClk);
    sleepMask = 1'b1;
    repeat (40) @(negedge busClk);
    begin
      bit wentHigh;
      wentHigh = 0;
      for (int k = 0; k < 30; k++) begin
        @(negedge busClk);
        if (gclkOut) wentHigh = 1;
      end
      check(!wentHigh, "R8 output held low by mask", wentHigh, 0);
    end
    check(rdData[15] == 1'b1, "R8 enable still set under mask", rdData[15], 1);
    @(negedge busClk);
    sleepMask = 1'b0;
    measure(halfOf(1, 1, 2), "R8 resumed period");
    stopAndCheck(1, 1, 2);

    // R9 R10: repeated enable/disable, prescaler restarts each time
    for (int n = 0; n < 3; n++) begin
      runConfig(0, 1, 0, "R3 div0 src0");
      stopAndCheck(0, 1, 0);
      runConfig(2, 1, 4, "R9 div4 restart");
      stopAndCheck(2, 1, 4);
    end

    runtArmed = 0;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule